// File: doc/BRIEF.md
# Interrupt Flag and Enable Aggregator

This block collects interrupt events from seven sources inside a peripheral: two control lines on side A, two on side B, a shift-complete event and two timer timeouts. Each source owns one pending flag. A flag is raised by a one-cycle set pulse from its source. It is dropped by a one-cycle clear pulse from the same source, which the source unit produces as a side effect of a host access to it. The host can also drop a flag by writing a one to its position.

A seven-bit enable mask selects which pending flags may interrupt the processor. The host writes the mask with a set/clear encoding: bit 7 of the written byte chooses whether the bits marked 1 are turned on or turned off. The bits marked 0 stay as they were. The block reports a summary bit in bit 7 of the flag register, which is the OR of all pending, enabled flags. It also drives an active-low interrupt request that follows the summary bit.

The host sees two byte-wide registers behind one select bit. The read path is combinational. A write takes effect at the clock edge where the write strobe is sampled. All control pins are plain, with no handshake.

Top module: `irq_agg_ctrl`

## Requirements
- R1: Flag bit i (0..6) sets on the clock edge after `src_set[i]` is high. The bit order is: 0 line A2, 1 line A1, 2 shift complete, 3 line B2, 4 line B1, 5 timer 2 timeout, 6 timer 1 timeout. A set flag stays set until it is cleared.
- R2: A high `src_clr[i]` clears flag i at the next edge.
- R3: Writing the flag register (`host_sel`=0) clears every flag in bits 6:0 that the written byte marks with 1. Bits marked 0 are unchanged, and written bit 7 has no effect.
- R4: If a set pulse and any clear (pulse or host write) reach the same flag in the same cycle, the flag ends up set.
- R5: Writing the enable register (`host_sel`=1) with bit 7 = 1 turns on each enable in bits 6:0 marked 1 and leaves the others unchanged.
- R6: Writing the enable register with bit 7 = 0 turns off each enable marked 1 and leaves the others unchanged.
- R7: Reading with `host_sel`=1 returns 1 in bit 7 and the current enables in bits 6:0.
- R8: Reading with `host_sel`=0 returns the flags in bits 6:0. Bit 7 is 1 exactly when some flag is set and its enable is set.
- R9: `irq_n` is 0 exactly when the summary bit of R8 is 1, and 1 otherwise.
- R10: Reset (`rst_n`=0) clears all flags and all enables, so `irq_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_set | input | 7 | Per-source event pulses that set flags |
| src_clr | input | 7 | Per-source clear pulses from access side effects |
| host_sel | input | 1 | Register select: 0 flags, 1 enables |
| host_wr | input | 1 | Write strobe for the selected register |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data of the selected register |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
A flag can receive a set event and a clear in the same cycle. The clear can come from its source's clear pulse or from a host write of ones to the flag register. The bench provokes this both in directed cases and in random cycles, where set, clear and write vectors overlap freely. It judges the result against a model in which the set wins. A second overlap exercised is a mask write in the same cycle as a flag change, with the summary bit and `irq_n` compared after that edge.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int SRC_N  = 7;
  localparam int DATA_W = 8;
  localparam int TOP_B  = DATA_W - 1;

  typedef enum int {
    SRC_LINE_A2    = 0,
    SRC_LINE_A1    = 1,
    SRC_SHIFT_DONE = 2,
    SRC_LINE_B2    = 3,
    SRC_LINE_B1    = 4,
    SRC_TMR2       = 5,
    SRC_TMR1       = 6
  } src_idx_e;

  typedef enum logic {
    SEL_FLAGS = 1'b0,
    SEL_MASK  = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] wclr_i,
  output logic [N-1:0] flags_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        flags_o[i] <= 1'b0;
      else if (set_i[i])
        flags_o[i] <= 1'b1;
      else if (clr_i[i] || wclr_i[i])
        flags_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic         polarity_i,
  input  logic [N-1:0] sel_bits_i,
  output logic [N-1:0] mask_o
);
  for (genvar i = 0; i < N; i++) begin : g_mask
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mask_o[i] <= 1'b0;
      else if (wr_i && sel_bits_i[i])
        mask_o[i] <= polarity_i;
    end
  end
endmodule

// File: rtl/irq_readback.sv
module irq_readback
  import irq_agg_pkg::*;
#(
  parameter int N = SRC_N,
  parameter int W = DATA_W
) (
  input  logic [N-1:0] flags_i,
  input  logic [N-1:0] mask_i,
  input  logic         sel_i,
  output logic         pending_o,
  output logic [W-1:0] rdata_o
);
  always_comb begin
    pending_o = |(flags_i & mask_i);
    rdata_o   = '0;
    if (sel_i == SEL_MASK) begin
      rdata_o[W-1]   = 1'b1;
      rdata_o[N-1:0] = mask_i;
    end else begin
      rdata_o[W-1]   = pending_o;
      rdata_o[N-1:0] = flags_i;
    end
  end
endmodule

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_N-1:0]  src_set,
  input  logic [SRC_N-1:0]  src_clr,
  input  logic              host_sel,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              irq_n
);
  logic [SRC_N-1:0] flag_q;
  logic [SRC_N-1:0] mask_q;
  logic [SRC_N-1:0] wclr;
  logic             mask_wr;
  logic             pending;

  // Host writes to the flag register act as clear requests on bits marked 1.
  assign wclr    = (host_wr && host_sel == SEL_FLAGS) ? host_wdata[SRC_N-1:0] : '0;
  assign mask_wr = host_wr && host_sel == SEL_MASK;

  irq_flag_bank #(.N(SRC_N)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (src_set),
    .clr_i   (src_clr),
    .wclr_i  (wclr),
    .flags_o (flag_q)
  );

  irq_mask_reg #(.N(SRC_N)) u_mask (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_i       (mask_wr),
    .polarity_i (host_wdata[TOP_B]),
    .sel_bits_i (host_wdata[SRC_N-1:0]),
    .mask_o     (mask_q)
  );

  irq_readback #(.N(SRC_N), .W(DATA_W)) u_rd (
    .flags_i   (flag_q),
    .mask_i    (mask_q),
    .sel_i     (host_sel),
    .pending_o (pending),
    .rdata_o   (host_rdata)
  );

  assign irq_n = ~pending;
endmodule

// File: rtl/irq_agg_ctrl_chk.sv
module irq_agg_ctrl_chk
  import irq_agg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [SRC_N-1:0]  src_set,
  input logic [SRC_N-1:0]  src_clr,
  input logic              host_sel,
  input logic              host_wr,
  input logic [DATA_W-1:0] host_wdata,
  input logic [DATA_W-1:0] host_rdata,
  input logic              irq_n,
  input logic [SRC_N-1:0]  flag_q,
  input logic [SRC_N-1:0]  mask_q
);
  // R1 and R4: every set pulse leaves its flag set after the edge.
  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (src_set != '0) |=> ((flag_q & $past(src_set)) == $past(src_set)));

  // R2: a clear pulse without a set leaves the flag clear.
  assert_clr_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_clr & ~src_set) != '0) |=> ((flag_q & $past(src_clr & ~src_set)) == '0));

  // R3: a host write of ones clears the marked flags that see no set.
  assert_wr_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_sel == SEL_FLAGS) |=>
      ((flag_q & $past(host_wdata[SRC_N-1:0] & ~src_set)) == '0));

  // R5: set-polarity mask write.
  assert_mask_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_sel == SEL_MASK && host_wdata[TOP_B]) |=>
      ((mask_q & $past(host_wdata[SRC_N-1:0])) == $past(host_wdata[SRC_N-1:0])));

  // R6: clear-polarity mask write.
  assert_mask_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_sel == SEL_MASK && !host_wdata[TOP_B]) |=>
      ((mask_q & $past(host_wdata[SRC_N-1:0])) == '0));

  // R9: the request pin agrees with the summary bit seen on the read port.
  assert_irq_summary_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_sel == SEL_FLAGS) |-> (host_rdata[TOP_B] == !irq_n));

  // R7: the mask view always shows a 1 on top.
  assert_mask_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_sel == SEL_MASK) |-> host_rdata[TOP_B]);

  // R1: with no set, clear or write, flags hold.
  assert_flags_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (src_set == '0 && src_clr == '0 && !host_wr) |=> $stable(flag_q));

  // R10: while in reset, nothing is pending.
  assert_reset_state_R10: assert property (@(posedge clk)
    !rst_n |-> (flag_q == '0 && mask_q == '0 && irq_n));
endmodule

bind irq_agg_ctrl irq_agg_ctrl_chk u_chk (.*);

// File: tb/irq_agg_ctrl_tb.sv
`timescale 1ns/1ps
module irq_agg_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] src_set = '0;
  logic [6:0] src_clr = '0;
  logic       host_sel = 1'b0;
  logic       host_wr = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       irq_n;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [6:0] m_flags = '0;
  logic [6:0] m_mask = '0;

  always #4 clk = ~clk;

  irq_agg_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .src_set(src_set), .src_clr(src_clr),
    .host_sel(host_sel), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .irq_n(irq_n)
  );

  function automatic logic [6:0] next_flags(logic [6:0] f, logic [6:0] s, logic [6:0] c,
                                            logic wr, logic sel, logic [7:0] wd);
    logic [6:0] wc;
    wc = (wr && !sel) ? wd[6:0] : 7'h0;
    return (f & ~c & ~wc) | s;
  endfunction

  function automatic logic [6:0] next_mask(logic [6:0] m, logic wr, logic sel, logic [7:0] wd);
    if (!(wr && sel)) return m;
    return wd[7] ? (m | wd[6:0]) : (m & ~wd[6:0]);
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic observe(string tag);
    host_sel = 1'b0; #1;
    chk({tag, " R8 flag view"}, host_rdata, {|(m_flags & m_mask), m_flags});
    chk({tag, " R9 irq_n"}, {7'h0, irq_n}, {7'h0, ~|(m_flags & m_mask)});
    host_sel = 1'b1; #1;
    chk({tag, " R7 mask view"}, host_rdata, {1'b1, m_mask});
  endtask

  task automatic step(string tag, logic [6:0] s, logic [6:0] c, logic wr, logic sel, logic [7:0] wd);
    @(negedge clk);
    src_set = s; src_clr = c; host_wr = wr; host_sel = sel; host_wdata = wd;
    @(posedge clk);
    #1;
    m_flags = next_flags(m_flags, s, c, wr, sel, wd);
    m_mask  = next_mask(m_mask, wr, sel, wd);
    src_set = '0; src_clr = '0; host_wr = 1'b0;
    observe(tag);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(posedge clk);
    #1;
    observe("R10 in reset");
    @(negedge clk); rst_n = 1'b1;
    observe("R10 after reset");

    // R1: each source position sets only its own flag
    for (int i = 0; i < 7; i++) begin
      step("R1 set", 7'(1 << i), 7'h0, 1'b0, 1'b0, 8'h0);
      step("R2 clr", 7'h0, 7'(1 << i), 1'b0, 1'b0, 8'h0);
    end
    // R5/R6: mask set and clear with partial selections
    step("R5 mask on", 7'h0, 7'h0, 1'b1, 1'b1, 8'hA5);
    step("R5 mask keep", 7'h0, 7'h0, 1'b1, 1'b1, 8'h80);
    step("R6 mask off", 7'h0, 7'h0, 1'b1, 1'b1, 8'h05);
    step("R6 mask off none", 7'h0, 7'h0, 1'b1, 1'b1, 8'h00);
    // R9: enabled vs disabled pending flag
    step("R9 disabled flag", 7'h02, 7'h0, 1'b0, 1'b0, 8'h0);
    step("R9 enabled flag", 7'h20, 7'h0, 1'b0, 1'b0, 8'h0);
    // R3: write zeros and bit 7 leave flags; write ones clears
    step("R3 fill", 7'h7F, 7'h0, 1'b0, 1'b0, 8'h0);
    step("R3 write 80", 7'h0, 7'h0, 1'b1, 1'b0, 8'h80);
    step("R3 write 0", 7'h0, 7'h0, 1'b1, 1'b0, 8'h00);
    step("R3 write 21", 7'h0, 7'h0, 1'b1, 1'b0, 8'h21);
    // R4: set against pulse clear and against write clear
    step("R4 set vs pulse", 7'h40, 7'h40, 1'b0, 1'b0, 8'h0);
    step("R4 set vs write", 7'h01, 7'h0, 1'b1, 1'b0, 8'hFF);
    step("R4 set vs both", 7'h20, 7'h20, 1'b1, 1'b0, 8'h20);
    // Random mix
    for (int n = 0; n < 3000; n++) begin
      logic [6:0] s;
      logic [6:0] c;
      s = 7'($urandom & $urandom & $urandom);
      c = 7'($urandom & $urandom);
      step("R1-mix", s, c, 1'($urandom_range(0, 3) == 0), 1'($urandom), 8'($urandom));
    end
    // R10: reset in the middle clears everything
    step("R10 prep", 7'h7F, 7'h0, 1'b1, 1'b1, 8'hFF);
    @(negedge clk); rst_n = 1'b0;
    m_flags = '0; m_mask = '0;
    #1;
    observe("R10 mid reset");
    @(negedge clk); rst_n = 1'b1;
    step("R10 after", 7'h0, 7'h0, 1'b0, 1'b0, 8'h0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule